// File: doc/BRIEF.md
# Radix-4 Digit Multiplier with Shared Coefficient Multiples

This block forms the exact signed product of a fixed-point coefficient and an input word. It works through the input word two bits at a time instead of using a bit-level array. The odd multiple three times the coefficient cannot be made by shifting, so the block computes it once, next to the coefficient and twice the coefficient. All digit lanes then share these three values.

Each 2-bit digit of the input word goes to a small decoder. The decoder raises at most one of three select lines. An AND/OR cell uses that select to pass one multiple, or zero, as the digit's partial product. The partial products are aligned by digit position and summed. The top digit carries negative weight, so that two's-complement inputs give exact results. An optional register stage splits selection from summation, and the sum is always registered at the output.

A valid strobe travels alongside the data. The output register loads only when a result is valid and holds its value otherwise, so a new operand pair can be given in every cycle.

Top module: `radix4_digit_mult`

## Requirements
- R1: While reset is asserted, and after it is released until the first result arrives, `prodValid` is 0 and `prodOut` is 0.
- R2: Each result on `prodOut` equals the product of `coefIn` and `dataIn`, both read as two's complement. The result is exact and COEF_W+DATA_L bits wide, also in two's complement.
- R3: `dataIn` is split into DATA_L/2 digits. Digit k is `dataIn[2k+1:2k]` and has weight 4^k. Digit values 0, 1, 2 and 3 select the partial product 0, W, 2W and 3W. The decoder raises select line 0, 1 or 2 for values 1, 2 or 3, and raises none for value 0.
- R4: The most significant digit has negative weight. When `dataIn[DATA_L-1]` is 1, that digit counts as its value minus 4. Negative input words therefore multiply exactly.
- R5: A result appears with `prodValid` high exactly 1+PIPE_STAGE clock edges after the edge that sampled `validIn` high. With the default PIPE_STAGE of 1 this is two edges.
- R6: The most negative operands multiply exactly. For the default widths, -128 times -128 gives +16384. Mixed-sign extremes give -16256.
- R7: A cycle with `validIn` low produces no result: `prodValid` stays 0 in the matching output cycle and `prodOut` keeps the last valid result, whatever the operands were in that cycle.
- R8: Operands given with `validIn` high on consecutive edges give one correct result per cycle, in the order they were given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| validIn | input | 1 | Marks the operands on this edge as a request |
| coefIn | input | COEF_W | Coefficient W, two's complement |
| dataIn | input | DATA_L | Input word, two's complement, DATA_L even |
| prodValid | output | 1 | A result is present on prodOut |
| prodOut | output | COEF_W+DATA_L | Registered product, two's complement |

## Verification
The assertions assume that `coefIn`, `dataIn` and `validIn` are stable around each rising edge. They also assume that reset is held for at least one edge before operands are given, so that the latency and product checks compare only against requests sampled after reset. The stimulus changes inputs only on the falling edge and holds reset low for several cycles. It then sweeps every pair of 8-bit operands back to back and mixes in idle cycles that carry junk operands, to show that those operands leave no trace at the output.

// File: rtl/r4ppg_pkg.sv
package r4ppg_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic loadStage;   // capture selected partial products
    logic loadResult;  // capture the summed product
  } ppgStrobe_t;

endpackage

// File: rtl/r4_digit_decoder.sv
// Turns one 2-bit digit into a one-hot select over {W, 2W, 3W}.
module r4_digit_decoder (
  input  logic [1:0] digit,
  output logic [2:0] sel
);
  always_comb begin
    unique case (digit)
      2'd1:    sel = 3'b001;
      2'd2:    sel = 3'b010;
      2'd3:    sel = 3'b100;
      default: sel = 3'b000;
    endcase
  end
endmodule

// File: rtl/r4_and_or_cell.sv
// Gates each shared multiple with its select line and ORs the results.
module r4_and_or_cell #(
  parameter int MULT_W = 10
) (
  input  logic [MULT_W-1:0] mult1,
  input  logic [MULT_W-1:0] mult2,
  input  logic [MULT_W-1:0] mult3,
  input  logic [2:0]        sel,
  output logic [MULT_W-1:0] partProd
);
  always_comb begin
    partProd = ({MULT_W{sel[0]}} & mult1)
             | ({MULT_W{sel[1]}} & mult2)
             | ({MULT_W{sel[2]}} & mult3);
  end
endmodule

// File: rtl/r4ppg_datapath.sv
module r4ppg_datapath
  import r4ppg_pkg::*;
#(
  parameter int COEF_W     = 8,
  parameter int DATA_L     = 8,
  parameter int PIPE_STAGE = 1,
  localparam int NUM_DIGITS = DATA_L / 2,
  localparam int MULT_W     = COEF_W + 2,
  localparam int PROD_W     = COEF_W + DATA_L
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ppgStrobe_t              strobe,
  input  logic [COEF_W-1:0]       coefIn,
  input  logic [DATA_L-1:0]       dataIn,
  output logic [PROD_W-1:0]       prodOut,
  output logic [3*NUM_DIGITS-1:0] digitSel
);

  // Shared multiples, sign-extended so that 3W cannot overflow.
  logic [MULT_W-1:0] mult1, mult2, mult3;
  always_comb begin
    mult1 = MULT_W'(signed'(coefIn));
    mult2 = mult1 << 1;
    mult3 = mult1 + mult2;
  end

  // One decoder and one AND/OR cell per digit.
  logic [MULT_W-1:0] ppSel [NUM_DIGITS];
  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    r4_digit_decoder u_dec (
      .digit (dataIn[2*k +: 2]),
      .sel   (digitSel[3*k +: 3])
    );
    r4_and_or_cell #(.MULT_W(MULT_W)) u_cell (
      .mult1    (mult1),
      .mult2    (mult2),
      .mult3    (mult3),
      .sel      (digitSel[3*k +: 3]),
      .partProd (ppSel[k])
    );
  end

  // Negative weight of the top digit: subtract W * 4^NUM_DIGITS when the sign bit is set.
  logic [PROD_W-1:0] corrSel;
  always_comb begin
    corrSel = dataIn[DATA_L-1] ? {coefIn, {DATA_L{1'b0}}} : '0;
  end

  logic [MULT_W-1:0] ppUse [NUM_DIGITS];
  logic [PROD_W-1:0] corrUse;

  if (PIPE_STAGE != 0) begin : g_pipe
    logic [MULT_W-1:0] ppReg [NUM_DIGITS];
    logic [PROD_W-1:0] corrReg;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int k = 0; k < NUM_DIGITS; k++) ppReg[k] <= '0;
        corrReg <= '0;
      end else if (strobe.loadStage) begin
        for (int k = 0; k < NUM_DIGITS; k++) ppReg[k] <= ppSel[k];
        corrReg <= corrSel;
      end
    end
    always_comb begin
      for (int k = 0; k < NUM_DIGITS; k++) ppUse[k] = ppReg[k];
      corrUse = corrReg;
    end
  end else begin : g_flat
    always_comb begin
      for (int k = 0; k < NUM_DIGITS; k++) ppUse[k] = ppSel[k];
      corrUse = corrSel;
    end
  end

  // Shifted accumulation of the partial products.
  logic [PROD_W-1:0] sumAcc;
  always_comb begin
    sumAcc = -corrUse;
    for (int k = 0; k < NUM_DIGITS; k++) begin
      sumAcc = sumAcc + (PROD_W'(signed'(ppUse[k])) << (2 * k));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodOut <= '0;
    end else if (strobe.loadResult) begin
      prodOut <= sumAcc;
    end
  end

endmodule

// File: rtl/r4ppg_control.sv
module r4ppg_control
  import r4ppg_pkg::*;
#(
  parameter int PIPE_STAGE = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  output ppgStrobe_t strobe,
  output logic       prodValid
);

  if (PIPE_STAGE != 0) begin : g_pipe
    logic stageValid;
    always_ff @(posedge clk) begin
      if (!rstN) stageValid <= 1'b0;
      else       stageValid <= validIn;
    end
    always_comb begin
      strobe.loadStage  = validIn;
      strobe.loadResult = stageValid;
    end
  end else begin : g_flat
    always_comb begin
      strobe.loadStage  = 1'b0;
      strobe.loadResult = validIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) prodValid <= 1'b0;
    else       prodValid <= strobe.loadResult;
  end

endmodule

// File: rtl/radix4_digit_mult.sv
module radix4_digit_mult
  import r4ppg_pkg::*;
#(
  parameter int COEF_W     = 8,
  parameter int DATA_L     = 8,
  parameter int PIPE_STAGE = 1,
  localparam int NUM_DIGITS = DATA_L / 2,
  localparam int PROD_W     = COEF_W + DATA_L
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [COEF_W-1:0] coefIn,
  input  logic [DATA_L-1:0] dataIn,
  output logic              prodValid,
  output logic [PROD_W-1:0] prodOut
);

  ppgStrobe_t              strobe;
  logic [3*NUM_DIGITS-1:0] digitSel;

  r4ppg_control #(.PIPE_STAGE(PIPE_STAGE)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .strobe    (strobe),
    .prodValid (prodValid)
  );

  r4ppg_datapath #(
    .COEF_W     (COEF_W),
    .DATA_L     (DATA_L),
    .PIPE_STAGE (PIPE_STAGE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .coefIn   (coefIn),
    .dataIn   (dataIn),
    .prodOut  (prodOut),
    .digitSel (digitSel)
  );

endmodule

// File: rtl/r4ppg_checker.sv
module r4ppg_checker #(
  parameter int COEF_W     = 8,
  parameter int DATA_L     = 8,
  parameter int PIPE_STAGE = 1,
  localparam int NUM_DIGITS = DATA_L / 2,
  localparam int PROD_W     = COEF_W + DATA_L,
  localparam int LAT        = 1 + ((PIPE_STAGE != 0) ? 1 : 0)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    validIn,
  input logic [COEF_W-1:0]       coefIn,
  input logic [DATA_L-1:0]       dataIn,
  input logic                    prodValid,
  input logic [PROD_W-1:0]       prodOut,
  input logic [3*NUM_DIGITS-1:0] digitSel
);

  // Edges since reset release, saturating at the latency.
  logic [1:0] upCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                 upCnt <= '0;
    else if (upCnt < 2'(LAT))  upCnt <= upCnt + 2'd1;
  end
  logic armed;
  assign armed = (upCnt >= 2'(LAT));

  // Behavioural reference multiply.
  logic [PROD_W-1:0] refProd;
  assign refProd = PROD_W'(signed'(coefIn)) * PROD_W'(signed'(dataIn));

  // R5
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (prodValid == $past(validIn, LAT)));

  // R2 R4 R6
  product_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && prodValid) |-> (prodOut == $past(refProd, LAT)));

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !prodValid |-> $stable(prodOut));

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
    // R3
    digit_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(digitSel[3*k +: 3]));
    // R3
    digit_select_chk: assert property (@(posedge clk) disable iff (!rstN)
      (dataIn[2*k +: 2] != 2'd0) |-> (digitSel[3*k +: 3] == (3'b001 << (dataIn[2*k +: 2] - 2'd1))));
    // R3
    zero_digit_chk: assert property (@(posedge clk) disable iff (!rstN)
      (dataIn[2*k +: 2] == 2'd0) |-> (digitSel[3*k +: 3] == 3'b000));
  end

endmodule

bind radix4_digit_mult r4ppg_checker #(
  .COEF_W     (COEF_W),
  .DATA_L     (DATA_L),
  .PIPE_STAGE (PIPE_STAGE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .validIn   (validIn),
  .coefIn    (coefIn),
  .dataIn    (dataIn),
  .prodValid (prodValid),
  .prodOut   (prodOut),
  .digitSel  (digitSel)
);

// File: tb/test_radix4_digit_mult.sv
`timescale 1ns/1ps
module test_radix4_digit_mult;

  localparam int CW = 8;
  localparam int DL = 8;
  localparam int PW = CW + DL;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          validIn = 1'b0;
  logic [CW-1:0] coefIn = '0;
  logic [DL-1:0] dataIn = '0;
  logic          prodValid;
  logic [PW-1:0] prodOut;

  always #4 clk = ~clk;

  radix4_digit_mult #(.COEF_W(CW), .DATA_L(DL), .PIPE_STAGE(1)) i_radix4_digit_mult (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .coefIn    (coefIn),
    .dataIn    (dataIn),
    .prodValid (prodValid),
    .prodOut   (prodOut)
  );

  int vecCnt = 0;
  int missCnt = 0;
  bit finished = 1'b0;

  // Requests given two falling edges ago become visible now (R5, latency 2).
  logic          histV [2] = '{1'b0, 1'b0};
  logic [PW-1:0] histE [2] = '{'0, '0};
  string         histT [2] = '{"R1", "R1"};
  logic [PW-1:0] lastGood = '0;

  task automatic checkOut();
    vecCnt++;
    if (histV[1]) begin
      if (prodValid !== 1'b1 || prodOut !== histE[1]) begin
        missCnt++;
        $display("FAIL %s/R5: got valid=%0b prod=%0d, expected valid=1 prod=%0d",
                 histT[1], prodValid, $signed(prodOut), $signed(histE[1]));
      end
      lastGood = histE[1];
    end else begin
      if (prodValid !== 1'b0 || prodOut !== lastGood) begin
        missCnt++;
        $display("FAIL R7: got valid=%0b prod=%0d, expected valid=0 prod=%0d",
                 prodValid, $signed(prodOut), $signed(lastGood));
      end
    end
  endtask

  task automatic applyVec(input logic v, input logic [CW-1:0] w, input logic [DL-1:0] x,
                          input string tag);
    @(negedge clk);
    checkOut();
    histV[1] = histV[0];
    histE[1] = histE[0];
    histT[1] = histT[0];
    histV[0] = v;
    histE[0] = PW'(signed'(w)) * PW'(signed'(x));
    histT[0] = tag;
    validIn = v;
    coefIn  = w;
    dataIn  = x;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    vecCnt++;
    if (prodValid !== 1'b0 || prodOut !== '0) begin
      missCnt++;
      $display("FAIL R1: got valid=%0b prod=%0d, expected valid=0 prod=0",
               prodValid, $signed(prodOut));
    end
    rstN = 1'b1;
    applyVec(1'b0, 8'h5A, 8'hA5, "R1");
    applyVec(1'b0, 8'h00, 8'h00, "R1");

    // R3: each digit value at each position, positive coefficient
    applyVec(1'b1, 8'd5,   8'b00_01_10_11, "R3");
    applyVec(1'b1, 8'd5,   8'b00_11_00_01, "R3");
    applyVec(1'b1, 8'd77,  8'b00_10_10_10, "R3");
    applyVec(1'b1, 8'd127, 8'b00_11_11_11, "R3");
    // R4: negative top digit
    applyVec(1'b1, 8'd9,   8'b11_00_00_00, "R4");
    applyVec(1'b1, 8'd9,   8'b10_00_00_01, "R4");
    // R6: extremes
    applyVec(1'b1, 8'h80,  8'h80, "R6");
    applyVec(1'b1, 8'h80,  8'h7F, "R6");
    applyVec(1'b1, 8'h7F,  8'h80, "R6");
    // R7: idle cycles with junk operands between results
    applyVec(1'b0, 8'hFF,  8'hFF, "R7");
    applyVec(1'b0, 8'h13,  8'h37, "R7");
    applyVec(1'b0, 8'h80,  8'h80, "R7");
    applyVec(1'b1, 8'hF3,  8'h21, "R2");
    applyVec(1'b0, 8'h44,  8'h44, "R7");
    applyVec(1'b1, 8'h02,  8'hFE, "R4");
    applyVec(1'b0, 8'h7F,  8'h7F, "R7");
    applyVec(1'b0, 8'h00,  8'h00, "R7");

    // R8: exhaustive back-to-back sweep, one result per cycle
    for (int a = -128; a < 128; a++) begin
      for (int b = -128; b < 128; b++) begin
        string tg;
        if (a == -128 && b == -128)      tg = "R6";
        else if (b < 0)                  tg = "R4";
        else if (a == 0 || b == 0)       tg = "R3";
        else                             tg = "R8";
        applyVec(1'b1, 8'(a), 8'(b), tg);
      end
    end
    applyVec(1'b0, 8'h11, 8'h22, "R7");
    applyVec(1'b0, 8'h33, 8'h44, "R7");
    applyVec(1'b0, 8'h00, 8'h00, "R7");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      missCnt++;
      $display("FAIL watchdog: got no completion, expected completion within 200000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

endmodule